// File: doc/BRIEF.md
# FIFO Service Request and Interrupt Flag Unit

This unit sits beside the byte FIFO of an I2C master controller. While a transfer holds the selected bus, it decides on every clock whether software must service the FIFO. A read transfer must drain bytes. A write transfer must refill them. The unit compares the FIFO fill level with a high and a low threshold. It also looks at two residual byte counts: the front-end count, for bytes still to cross the wire, and the back-end count, for bytes still to cross the host interface.

When both residual counts reach zero, the command is complete. The unit then withdraws the service request and sets its completion flag. If the command asked for a stop condition, it also asks the bus engine to release the bus. The service request, the completion flag and a few condition bits from neighbouring logic form a raw condition vector. A mask selects bits of that vector, and a single interrupt line reports whether any selected bit is set.

Every flag is a register. A flag reflects the inputs present at the preceding rising clock edge. All pins are plain control and status signals. No data stream passes through the unit, so it has no valid/ready handshake and applies no back-pressure.

Top module: `wdr_datareq_irq`

## Requirements
- R1: After reset, `high_water`, `low_water`, `data_req` and `release_bus` are 0, and `cmd_done` is 1.
- R2: While `bus_busy` is 0, `high_water`, `low_water`, `data_req` and `cmd_done` keep their values across clock edges, and `release_bus` is 0.
- R3: On an edge with `bus_busy`=1 and `dir_read`=1, `high_water` becomes 1 if `fifo_count` >= `hi_mark`, and 0 otherwise.
- R4: On an edge with `bus_busy`=1, `dir_read`=1 and at least one residual count nonzero, `data_req` becomes 1 exactly when the FIFO is non-empty with the new `high_water` equal to 1, or when `front_resid` is 0.
- R5: On an edge with `bus_busy`=1 and `dir_read`=0, `low_water` becomes 1 if `fifo_count` <= `lo_mark`, and 0 otherwise.
- R6: On an edge with `bus_busy`=1, `dir_read`=0 and at least one residual count nonzero, `data_req` becomes 1 exactly when `back_resid` is nonzero and either (DEPTH − `fifo_count`) >= `back_resid` or the new `low_water` is 1.
- R7: On an edge with `bus_busy`=1 where both residual counts are 0, `data_req` becomes 0 and `cmd_done` becomes 1. On any other edge with `bus_busy`=1, `cmd_done` becomes 0.
- R8: `release_bus` is 1 for the cycle that follows an edge with `bus_busy`=1, both residual counts 0 and `stop_req`=1. After every other edge it is 0.
- R9: `raw_cond` holds `data_req` in bit 0, `cmd_done` in bit 1 and `ext_cond` in bits 2 and up. `masked_cond` equals `raw_cond` AND `irq_mask`, and `irq` is 1 exactly when `masked_cond` is nonzero. All three follow their inputs in the same cycle.
- R10: A busy edge in read direction leaves `low_water` unchanged, and a busy edge in write direction leaves `high_water` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_busy | input | 1 | The selected bus is held by a transfer |
| dir_read | input | 1 | 1 for a read transfer, 0 for a write transfer |
| stop_req | input | 1 | The current command ends with a stop condition |
| fifo_count | input | CNT_W | Bytes held in the FIFO, 0 to DEPTH |
| hi_mark | input | CNT_W | High threshold, used on reads |
| lo_mark | input | CNT_W | Low threshold, used on writes |
| front_resid | input | RES_W | Bytes left to move on the wire |
| back_resid | input | RES_W | Bytes left to move across the host interface |
| ext_cond | input | EXT_W | Other condition bits of the status word |
| irq_mask | input | COND_W | Interrupt enable per condition bit |
| high_water | output | 1 | High-threshold flag |
| low_water | output | 1 | Low-threshold flag |
| data_req | output | 1 | Software must service the FIFO |
| cmd_done | output | 1 | Command complete |
| release_bus | output | 1 | Request to end the transfer and drop the busy bits |
| raw_cond | output | COND_W | Unmasked condition vector |
| masked_cond | output | COND_W | Condition vector after the mask |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that `fifo_count` never exceeds DEPTH, so the free-space figure never wraps. They also assume that `rst_n` is held low for at least one edge before any checked behaviour. The stimulus keeps to these limits. It sweeps the fill count only from 0 to DEPTH, and it sweeps both thresholds over the same range. It holds reset for several cycles at the start. Before each evaluation, the sweeps drive the residual counts, the direction and the stop flag to fixed legal values.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic [0:0] {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } wdr_dir_e;

  localparam int COND_DREQ_BIT = 0;
  localparam int COND_DONE_BIT = 1;
  localparam int COND_EXT_LSB  = 2;

  typedef struct packed {
    logic hi;
    logic lo;
    logic dreq;
    logic done;
  } wdr_flags_t;
endpackage

// File: rtl/wdr_read_eval.sv
module wdr_read_eval #(
  parameter int CNT_W = 4,
  parameter int RES_W = 8
) (
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] hi_mark,
  input  logic [RES_W-1:0] front_resid,
  output logic             hi_next,
  output logic             dreq_next
);
  always_comb begin
    hi_next   = (fifo_count >= hi_mark);
    dreq_next = (hi_next && (fifo_count != '0)) || (front_resid == '0);
  end
endmodule

// File: rtl/wdr_write_eval.sv
module wdr_write_eval #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int RES_W = 8
) (
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] lo_mark,
  input  logic [RES_W-1:0] back_resid,
  output logic             lo_next,
  output logic             dreq_next
);
  int free_space;

  always_comb begin
    free_space = DEPTH - int'(fifo_count);
    lo_next    = (fifo_count <= lo_mark);
    dreq_next  = (back_resid != '0) &&
                 ((free_space >= int'(back_resid)) || lo_next);
  end
endmodule

// File: rtl/wdr_irq_map.sv
module wdr_irq_map
  import wdr_pkg::*;
#(
  parameter int EXT_W  = 2,
  parameter int COND_W = EXT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_req,
  input  logic              cmd_done,
  input  logic [EXT_W-1:0]  ext_cond,
  input  logic [COND_W-1:0] irq_mask,
  output logic [COND_W-1:0] raw_cond,
  output logic [COND_W-1:0] masked_cond,
  output logic              irq
);
  always_comb begin
    raw_cond                                = '0;
    raw_cond[COND_DREQ_BIT]                 = data_req;
    raw_cond[COND_DONE_BIT]                 = cmd_done;
    raw_cond[COND_EXT_LSB +: EXT_W]         = ext_cond;
    masked_cond                             = raw_cond & irq_mask;
    irq                                     = |masked_cond;
  end

  // R9: an asserted line needs at least one enabled, active condition.
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((irq_mask != '0) && (raw_cond != '0)));
endmodule

// File: rtl/wdr_datareq_irq.sv
module wdr_datareq_irq
  import wdr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int RES_W  = 8,
  parameter int EXT_W  = 2,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int COND_W = EXT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_busy,
  input  logic              dir_read,
  input  logic              stop_req,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic [CNT_W-1:0]  hi_mark,
  input  logic [CNT_W-1:0]  lo_mark,
  input  logic [RES_W-1:0]  front_resid,
  input  logic [RES_W-1:0]  back_resid,
  input  logic [EXT_W-1:0]  ext_cond,
  input  logic [COND_W-1:0] irq_mask,
  output logic              high_water,
  output logic              low_water,
  output logic              data_req,
  output logic              cmd_done,
  output logic              release_bus,
  output logic [COND_W-1:0] raw_cond,
  output logic [COND_W-1:0] masked_cond,
  output logic              irq
);
  wdr_flags_t flags_q;
  logic       rd_hi, rd_dreq, wr_lo, wr_dreq;
  logic       both_zero;
  wdr_dir_e   dir;

  assign dir       = wdr_dir_e'(dir_read);
  assign both_zero = (front_resid == '0) && (back_resid == '0);

  wdr_read_eval #(.CNT_W(CNT_W), .RES_W(RES_W)) u_rd (
    .fifo_count (fifo_count),
    .hi_mark    (hi_mark),
    .front_resid(front_resid),
    .hi_next    (rd_hi),
    .dreq_next  (rd_dreq)
  );

  wdr_write_eval #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RES_W(RES_W)) u_wr (
    .fifo_count (fifo_count),
    .lo_mark    (lo_mark),
    .back_resid (back_resid),
    .lo_next    (wr_lo),
    .dreq_next  (wr_dreq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q     <= '{hi: 1'b0, lo: 1'b0, dreq: 1'b0, done: 1'b1};
      release_bus <= 1'b0;
    end else begin
      release_bus <= 1'b0;
      if (bus_busy) begin
        if (dir == DIR_READ) flags_q.hi <= rd_hi;
        else                 flags_q.lo <= wr_lo;
        if (both_zero) begin
          flags_q.dreq <= 1'b0;
          flags_q.done <= 1'b1;
          release_bus  <= stop_req;
        end else begin
          flags_q.done <= 1'b0;
          flags_q.dreq <= (dir == DIR_READ) ? rd_dreq : wr_dreq;
        end
      end
    end
  end

  assign high_water = flags_q.hi;
  assign low_water  = flags_q.lo;
  assign data_req   = flags_q.dreq;
  assign cmd_done   = flags_q.done;

  wdr_irq_map #(.EXT_W(EXT_W), .COND_W(COND_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_req   (flags_q.dreq),
    .cmd_done   (flags_q.done),
    .ext_cond   (ext_cond),
    .irq_mask   (irq_mask),
    .raw_cond   (raw_cond),
    .masked_cond(masked_cond),
    .irq        (irq)
  );

  // Input assumption: the fill count never exceeds the FIFO depth.
  p_count_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= DEPTH);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |=> ($stable({high_water, low_water, data_req, cmd_done}) && !release_bus));

  p_hi_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && dir_read) |=> (high_water == $past(fifo_count >= hi_mark)));

  p_lo_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !dir_read) |=> (low_water == $past(fifo_count <= lo_mark)));

  p_done_excludes_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !data_req);

  p_release_implies_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    release_bus |-> cmd_done);

  p_other_mark_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && dir_read) |=> $stable(low_water));
endmodule

// File: tb/tb_wdr_datareq_irq.sv
`timescale 1ns/1ps
module tb_wdr_datareq_irq;
  localparam int DEPTH = 8;
  localparam int CNT_W = 4;
  localparam int RES_W = 8;
  localparam int EXT_W = 2;
  localparam int COND_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_busy = 1'b0, dir_read = 1'b0, stop_req = 1'b0;
  logic [CNT_W-1:0] fifo_count = '0, hi_mark = '0, lo_mark = '0;
  logic [RES_W-1:0] front_resid = '0, back_resid = '0;
  logic [EXT_W-1:0] ext_cond = '0;
  logic [COND_W-1:0] irq_mask = '0;
  logic high_water, low_water, data_req, cmd_done, release_bus, irq;
  logic [COND_W-1:0] raw_cond, masked_cond;

  int checks = 0;
  int errors = 0;
  int e_hi = 0, e_lo = 0, e_dreq = 0, e_done = 1, e_rel = 0;

  always #2 clk = ~clk;

  wdr_datareq_irq #(.DEPTH(DEPTH), .RES_W(RES_W), .EXT_W(EXT_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .dir_read(dir_read),
    .stop_req(stop_req), .fifo_count(fifo_count), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .front_resid(front_resid), .back_resid(back_resid),
    .ext_cond(ext_cond), .irq_mask(irq_mask), .high_water(high_water),
    .low_water(low_water), .data_req(data_req), .cmd_done(cmd_done),
    .release_bus(release_bus), .raw_cond(raw_cond),
    .masked_cond(masked_cond), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " high_water"}, int'(high_water), e_hi);
    chk({tag, " low_water"}, int'(low_water), e_lo);
    chk({tag, " data_req"}, int'(data_req), e_dreq);
    chk({tag, " cmd_done"}, int'(cmd_done), e_done);
    chk({tag, " release_bus"}, int'(release_bus), e_rel);
  endtask

  // One busy evaluation with the reference model applied.
  task automatic eval(input int rd, input int cnt, input int mark,
                      input int fr, input int bk, input int stp, input string tag);
    @(negedge clk);
    bus_busy = 1'b1; dir_read = rd[0]; stop_req = stp[0];
    fifo_count = CNT_W'(cnt); hi_mark = CNT_W'(mark); lo_mark = CNT_W'(mark);
    front_resid = RES_W'(fr); back_resid = RES_W'(bk);
    if (rd != 0) e_hi = (cnt >= mark) ? 1 : 0;   // R3, R10
    else         e_lo = (cnt <= mark) ? 1 : 0;   // R5, R10
    if (fr == 0 && bk == 0) begin                // R7, R8
      e_dreq = 0; e_done = 1; e_rel = stp;
    end else begin
      e_done = 0; e_rel = 0;
      if (rd != 0) e_dreq = ((e_hi == 1 && cnt != 0) || fr == 0) ? 1 : 0;           // R4
      else e_dreq = (bk != 0 && ((DEPTH - cnt) >= bk || e_lo == 1)) ? 1 : 0;       // R6
    end
    @(posedge clk); #1;
    chk_flags(tag);
  endtask

  task automatic irq_sweep(input string tag);
    for (int x = 0; x < (1 << EXT_W); x++) begin
      for (int m = 0; m < (1 << COND_W); m++) begin
        int raw;
        @(negedge clk);
        ext_cond = EXT_W'(x); irq_mask = COND_W'(m);
        #1;
        raw = (x << 2) | (e_done << 1) | e_dreq;
        chk({tag, " R9 raw_cond"}, int'(raw_cond), raw);
        chk({tag, " R9 masked_cond"}, int'(masked_cond), raw & m);
        chk({tag, " R9 irq"}, int'(irq), ((raw & m) != 0) ? 1 : 0);
      end
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk_flags("R1 reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk_flags("R1 after release");

    // Read direction sweep: R3 R4 R7 R8 R10
    for (int c = 0; c <= DEPTH; c++)
      for (int mk = 0; mk <= DEPTH; mk++)
        for (int f = 0; f < 3; f++)
          for (int b = 0; b < 2; b++)
            eval(1, c, mk, (f == 2) ? 3 : f, b * 2, c & 1, "R3/R4/R7/R8/R10 read");

    irq_sweep("state after read");

    // Write direction sweep: R5 R6 R7 R8 R10
    for (int c = 0; c <= DEPTH; c++)
      for (int mk = 0; mk <= DEPTH; mk++)
        for (int b = 0; b <= DEPTH + 1; b++)
          for (int f = 0; f < 2; f++)
            eval(0, c, mk, f, b, (c + mk) & 1, "R5/R6/R7/R8/R10 write");

    // Completion with and without stop in both directions
    eval(1, 2, 1, 0, 0, 1, "R8 read stop");
    eval(1, 2, 1, 0, 0, 0, "R8 read nostop");
    eval(0, 5, 3, 0, 0, 1, "R7 write stop");
    irq_sweep("state done");
    eval(1, 4, 4, 2, 2, 0, "R4 read request");
    irq_sweep("state dreq");

    // Idle hold: R2
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      bus_busy = 1'b0; dir_read = k[0]; stop_req = 1'b1;
      fifo_count = CNT_W'(k); hi_mark = '0; lo_mark = CNT_W'(DEPTH);
      front_resid = '0; back_resid = '0;
      e_rel = 0;
      @(posedge clk); #1;
      chk_flags("R2 idle hold");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule